// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital controller that wraps a successive-approximation converter. It keeps the converter's enable, busy, clock-select and channel-select bits. It also keeps a register that marks pins as analog. A conversion starts from a software write of the busy bit or from an external special-event trigger. Each conversion runs ten bit decisions, from the MSB down to the LSB, against a one-bit comparator input. At the end it loads the high and low result registers and sets an interrupt flag.

The block also follows the core's sleep state. With the internal RC clock selected (clock-select `2'b11`), a start first waits one instruction cycle, so that the core can execute its sleep instruction. The conversion then continues through sleep. When it completes during sleep, the block either asks the core to wake, or powers the converter down quietly while the enable bit stays set. With any other clock selected, entering sleep aborts the conversion and powers the converter down.

The sequencer has four states:
- `S_IDLE`: no conversion in progress.
- `S_DELAY`: the instruction-cycle wait taken only with the RC clock.
- `S_CONV`: the bit decisions.
- `S_DOWN`: powered down during sleep.

Its transitions are:
- IDLE→DELAY: start with the RC clock.
- IDLE→CONV: start with a divided clock.
- IDLE→DOWN: sleep with a divided clock.
- DELAY→CONV: wait elapsed.
- DELAY→IDLE: abort.
- CONV→IDLE: done, or abort.
- CONV→DOWN: sleep abort with a divided clock, or completion in sleep with the interrupt disabled.
- DOWN→IDLE: sleep ends, or the enable is cleared.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `en_o`=0, `busy_o`=0, `pwr_o`=0 and `flag_o`=0, and every bit of `ana_sel_o` is 1 (all pins analog).
- R2: Reset does not change `res_hi_o`/`res_lo_o`.
- R3: A control write with enable=1 and go=1 starts a conversion of ten MSB-first decisions. In each decision the trial bit is kept when `cmp_i`=1 (input at or above `dac_o`). The result equals the comparator-derived code. With clock-select 0, 1 or 2, `busy_o` stays high for exactly 10×P clocks, where P is 2, 8 or 32.
- R4: At completion, `busy_o` clears, `res_hi_o`=result[9:8], `res_lo_o`=result[7:0], and `flag_o` sets whatever the value of `ie_i`. A pulse on `flag_clr_i` clears the flag.
- R5: A control write with go=0 during a conversion aborts it. The result registers stay unchanged and the flag is not set.
- R6: `trig_i` starts a conversion when `en_o`=1. When `en_o`=0 it is ignored: no busy, no flag, no result change.
- R7: With clock-select `2'b11`, the first decision comes INSTR_CYC (4) clocks after the start, and each decision waits for a `rc_tick_i` strobe. With the strobe held high, `busy_o` lasts 14 clocks.
- R8: An RC conversion that completes during sleep with `ie_i`=1 completes normally and raises `wake_o` for exactly one clock. `pwr_o` stays 1.
- R9: An RC conversion that completes during sleep with `ie_i`=0 sets the result and the flag. `pwr_o` then goes to 0 while `en_o` stays 1, and no wake pulse is raised. `pwr_o` returns to 1 once sleep ends.
- R10: Entering sleep with clock-select other than `2'b11` clears `busy_o` and `pwr_o` on the next clock and keeps `en_o`=1. The result and the flag stay unchanged.
- R11: A control write with go=1 and enable=0 does not start a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_en_i | input | 1 | Written enable bit |
| ctl_go_i | input | 1 | Written go/busy bit |
| ctl_clksel_i | input | 2 | Written clock select (11 = RC) |
| ctl_chan_i | input | CHAN_W | Written channel select |
| ana_we_i | input | 1 | Analog-select register write strobe |
| ana_wdata_i | input | ANA_W | Written analog-select bits |
| ie_i | input | 1 | Converter interrupt enable |
| flag_clr_i | input | 1 | Clears the interrupt flag |
| trig_i | input | 1 | Special-event start trigger |
| sleep_i | input | 1 | Core is in sleep |
| rc_tick_i | input | 1 | Internal RC converter clock strobe |
| cmp_i | input | 1 | Comparator: analog input ≥ trial code |
| en_o | output | 1 | Enable bit |
| busy_o | output | 1 | Go/busy bit |
| clksel_o | output | 2 | Clock select |
| chan_o | output | CHAN_W | Channel select |
| ana_sel_o | output | ANA_W | Analog-select bits |
| pwr_o | output | 1 | Converter powered |
| dac_o | output | RES_W | Current trial code |
| res_hi_o | output | RES_W-8 | Result high part |
| res_lo_o | output | 8 | Result low byte |
| flag_o | output | 1 | Interrupt flag |
| wake_o | output | 1 | Wake request pulse |

## Verification
The bench checks the length of each conversion for every divided clock. A divider off by one step would stretch or shorten `busy_o` by whole decision periods. It aborts a conversion by software and by a non-RC sleep, and confirms that the result registers and the flag stay as they were. A design that loaded the partial code, or set the flag on abort, would show a changed result. The RC path is checked in sleep with the interrupt enabled and disabled: a missing wake, a doubled wake pulse, or a cleared enable bit after power-down are each visible. A trigger and a go write while disabled are checked to start nothing. Reset is checked to set the analog-select bits while leaving the last result in place.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_DELAY = 2'd1,
        S_CONV  = 2'd2,
        S_DOWN  = 2'd3
    } seq_state_t;

    localparam int          SEL_W  = 2;
    localparam logic [1:0]  CLK_RC = 2'b11;
endpackage

// File: rtl/adc_step_timer.sv
module adc_step_timer #(
    parameter int BASE_LOG2 = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       run_i,
    input  logic       rc_sel_i,
    input  logic       rc_tick_i,
    input  logic [1:0] sel_i,
    output logic       tick_o
);
    localparam int CNT_W = BASE_LOG2 + 5;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim;
    int unsigned      shift;

    // decision period is 2^(BASE_LOG2 + 2*sel) clocks
    always_comb begin
        shift = BASE_LOG2 + 2 * 32'(sel_i);
        lim   = CNT_W'((32'd1 << shift) - 32'd1);
    end

    assign tick_o = run_i && (rc_sel_i ? rc_tick_i : (cnt_q == lim));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (run_i) begin
            cnt_q <= (cnt_q == lim) ? '0 : cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_i,
    input  logic             step_i,
    input  logic             cmp_i,
    output logic [RES_W-1:0] trial_o,
    output logic [RES_W-1:0] decided_o,
    output logic             last_o
);
    localparam int IDX_W = $clog2(RES_W);

    logic [RES_W-1:0] trial_q;
    logic [RES_W-1:0] nxt;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_m1;

    assign idx_m1 = idx_q - IDX_W'(1);

    always_comb begin
        decided_o         = trial_q;
        decided_o[idx_q]  = cmp_i;
        nxt               = decided_o;
        if (idx_q != '0) begin
            nxt[idx_m1] = 1'b1;
        end
    end

    assign trial_o = trial_q;
    assign last_o  = (idx_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial_q <= '0;
            idx_q   <= '0;
        end else if (init_i) begin
            trial_q <= RES_W'(1) << (RES_W - 1);
            idx_q   <= IDX_W'(RES_W - 1);
        end else if (step_i) begin
            trial_q <= nxt;
            if (idx_q != '0) begin
                idx_q <= idx_m1;
            end
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int INSTR_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       rc_sel_i,
    input  logic       sleep_i,
    input  logic       ie_i,
    input  logic       start_i,
    input  logic       abort_i,
    input  logic       tick_i,
    input  logic       last_i,
    output seq_state_t state_o,
    output logic       init_o,
    output logic       run_o,
    output logic       done_o,
    output logic       wake_o
);
    localparam int DLY_W = $clog2(INSTR_CYC + 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [DLY_W-1:0] dly_q;
    logic             sleep_kill;

    assign sleep_kill = sleep_i && !rc_sel_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            dly_q   <= '0;
        end else begin
            state_q <= state_d;
            dly_q   <= (state_q == S_DELAY) ? dly_q + DLY_W'(1) : '0;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (en_i && sleep_kill)        state_d = S_DOWN;
                else if (start_i)              state_d = rc_sel_i ? S_DELAY : S_CONV;
            end
            S_DELAY: begin
                if (abort_i)                   state_d = S_IDLE;
                else if (dly_q == DLY_W'(INSTR_CYC - 1)) state_d = S_CONV;
            end
            S_CONV: begin
                if (abort_i)                   state_d = S_IDLE;
                else if (sleep_kill)           state_d = S_DOWN;
                else if (tick_i && last_i)     state_d = (sleep_i && !ie_i) ? S_DOWN : S_IDLE;
            end
            S_DOWN: begin
                if (!sleep_i || !en_i)         state_d = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        state_o = state_q;
        init_o  = (state_d == S_CONV) && (state_q != S_CONV);
        run_o   = (state_q == S_CONV);
        done_o  = run_o && !abort_i && !sleep_kill && tick_i && last_i;
        wake_o  = done_o && sleep_i && ie_i;
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W     = 10,
    parameter int CHAN_W    = 3,
    parameter int ANA_W     = 7,
    parameter int INSTR_CYC = 4,
    parameter int BASE_LOG2 = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_we_i,
    input  logic                ctl_en_i,
    input  logic                ctl_go_i,
    input  logic [1:0]          ctl_clksel_i,
    input  logic [CHAN_W-1:0]   ctl_chan_i,
    input  logic                ana_we_i,
    input  logic [ANA_W-1:0]    ana_wdata_i,
    input  logic                ie_i,
    input  logic                flag_clr_i,
    input  logic                trig_i,
    input  logic                sleep_i,
    input  logic                rc_tick_i,
    input  logic                cmp_i,
    output logic                en_o,
    output logic                busy_o,
    output logic [1:0]          clksel_o,
    output logic [CHAN_W-1:0]   chan_o,
    output logic [ANA_W-1:0]    ana_sel_o,
    output logic                pwr_o,
    output logic [RES_W-1:0]    dac_o,
    output logic [RES_W-9:0]    res_hi_o,
    output logic [7:0]          res_lo_o,
    output logic                flag_o,
    output logic                wake_o
);
    logic               en_q;
    logic [1:0]         clksel_q;
    logic [CHAN_W-1:0]  chan_q;
    logic [ANA_W-1:0]   ana_q;
    logic               flag_q;
    logic [RES_W-1:0]   res_q;

    logic [1:0]         sel_eff;
    logic               rc_sel;
    logic               start_req;
    logic               abort_req;
    seq_state_t         state;
    logic               init;
    logic               run;
    logic               done;
    logic               tick;
    logic               last;
    logic [RES_W-1:0]   decided;

    assign sel_eff   = ctl_we_i ? ctl_clksel_i : clksel_q;
    assign rc_sel    = (sel_eff == CLK_RC);
    assign start_req = (ctl_we_i && ctl_en_i && ctl_go_i) ||
                       (trig_i && en_q && !(ctl_we_i && !ctl_en_i));
    assign abort_req = ctl_we_i && (!ctl_go_i || !ctl_en_i);

    adc_seq_fsm #(.INSTR_CYC(INSTR_CYC)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_q),
        .rc_sel_i (rc_sel),
        .sleep_i  (sleep_i),
        .ie_i     (ie_i),
        .start_i  (start_req),
        .abort_i  (abort_req),
        .tick_i   (tick),
        .last_i   (last),
        .state_o  (state),
        .init_o   (init),
        .run_o    (run),
        .done_o   (done),
        .wake_o   (wake_o)
    );

    adc_step_timer #(.BASE_LOG2(BASE_LOG2)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (init),
        .run_i     (run),
        .rc_sel_i  (clksel_q == CLK_RC),
        .rc_tick_i (rc_tick_i),
        .sel_i     (clksel_q),
        .tick_o    (tick)
    );

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_i    (init),
        .step_i    (tick),
        .cmp_i     (cmp_i),
        .trial_o   (dac_o),
        .decided_o (decided),
        .last_o    (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            clksel_q <= '0;
            chan_q   <= '0;
            ana_q    <= '1;
            flag_q   <= 1'b0;
        end else begin
            if (ctl_we_i) begin
                en_q     <= ctl_en_i;
                clksel_q <= ctl_clksel_i;
                chan_q   <= ctl_chan_i;
            end
            if (ana_we_i) begin
                ana_q <= ana_wdata_i;
            end
            if (done) begin
                flag_q <= 1'b1;
            end else if (flag_clr_i) begin
                flag_q <= 1'b0;
            end
        end
    end

    // result registers keep their value through reset
    always_ff @(posedge clk) begin
        if (done) begin
            res_q <= decided;
        end
    end

    assign en_o      = en_q;
    assign busy_o    = (state == S_DELAY) || (state == S_CONV);
    assign pwr_o     = en_q && (state != S_DOWN);
    assign clksel_o  = clksel_q;
    assign chan_o    = chan_q;
    assign ana_sel_o = ana_q;
    assign flag_o    = flag_q;
    assign res_hi_o  = res_q[RES_W-1:8];
    assign res_lo_o  = res_q[7:0];
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int RES_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we_i,
    input logic             ie_i,
    input logic             sleep_i,
    input logic [1:0]       clksel_o,
    input logic             en_o,
    input logic             busy_o,
    input logic             pwr_o,
    input logic             flag_o,
    input logic             wake_o,
    input logic [RES_W-1:0] res_w
);
    AST_BUSY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> en_o); // R11

    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_o && !ctl_we_i) |=> !busy_o); // R6

    AST_RESULT_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_w) |-> (flag_o && !busy_o)); // R4

    AST_WAKE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (ie_i && sleep_i && clksel_o == 2'b11)); // R8

    AST_SLEEP_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_i && clksel_o != 2'b11 && !ctl_we_i) |=> (!busy_o && !pwr_o)); // R10

    AST_PWR_DROP_KEEPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_o) && !$past(ctl_we_i)) |-> en_o); // R9
endmodule

bind adc_seq_ctrl adc_seq_chk #(.RES_W(RES_W)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_we_i (ctl_we_i),
    .ie_i     (ie_i),
    .sleep_i  (sleep_i),
    .clksel_o (clksel_o),
    .en_o     (en_o),
    .busy_o   (busy_o),
    .pwr_o    (pwr_o),
    .flag_o   (flag_o),
    .wake_o   (wake_o),
    .res_w    ({res_hi_o, res_lo_o})
);

// File: tb/test_adc_seq_ctrl.sv
`timescale 1ns/1ps
module test_adc_seq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_we, ctl_en, ctl_go;
    logic [1:0] ctl_sel;
    logic [2:0] ctl_chan;
    logic       ana_we;
    logic [6:0] ana_wdata;
    logic       ie, flag_clr, trig, sleep, rc_tick;
    logic       cmp;
    logic       en_o, busy_o, pwr_o, flag_o, wake_o;
    logic [1:0] clksel_o;
    logic [2:0] chan_o;
    logic [6:0] ana_sel_o;
    logic [9:0] dac_o;
    logic [1:0] res_hi_o;
    logic [7:0] res_lo_o;
    logic [9:0] vin;
    logic [9:0] res;

    int checks = 0;
    int fails  = 0;
    int wake_cnt = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    assign cmp = (vin >= dac_o);
    assign res = {res_hi_o, res_lo_o};

    adc_seq_ctrl i_adc_seq_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctl_we_i(ctl_we), .ctl_en_i(ctl_en), .ctl_go_i(ctl_go),
        .ctl_clksel_i(ctl_sel), .ctl_chan_i(ctl_chan),
        .ana_we_i(ana_we), .ana_wdata_i(ana_wdata),
        .ie_i(ie), .flag_clr_i(flag_clr), .trig_i(trig), .sleep_i(sleep),
        .rc_tick_i(rc_tick), .cmp_i(cmp),
        .en_o(en_o), .busy_o(busy_o), .clksel_o(clksel_o), .chan_o(chan_o),
        .ana_sel_o(ana_sel_o), .pwr_o(pwr_o), .dac_o(dac_o),
        .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .flag_o(flag_o), .wake_o(wake_o)
    );

    always @(negedge clk) if (wake_o) wake_cnt++;

    // sel[23:22], analog value[21:12], expected busy clocks[11:0]
    localparam logic [23:0] VEC [6] = '{
        {2'd0, 10'h000, 12'd20},
        {2'd0, 10'h3FF, 12'd20},
        {2'd1, 10'h2AA, 12'd80},
        {2'd2, 10'h155, 12'd320},
        {2'd0, 10'h200, 12'd20},
        {2'd1, 10'h1FF, 12'd80}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic en, input logic go, input logic [1:0] sel);
        @(negedge clk);
        ctl_we = 1'b1; ctl_en = en; ctl_go = go; ctl_sel = sel; ctl_chan = 3'd5;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int w0;
        rst_n = 1'b0; ctl_we = 0; ctl_en = 0; ctl_go = 0; ctl_sel = 0; ctl_chan = 0;
        ana_we = 0; ana_wdata = 0; ie = 0; flag_clr = 0; trig = 0; sleep = 0;
        rc_tick = 0; vin = 0;
        repeat (3) @(negedge clk);
        chk(en_o == 0 && busy_o == 0 && pwr_o == 0 && flag_o == 0, "R1 reset outputs",
            {en_o, busy_o, pwr_o, flag_o}, 0);
        chk(ana_sel_o == 7'h7F, "R1 analog select", ana_sel_o, 7'h7F);
        rst_n = 1'b1;
        @(negedge clk);
        chk(en_o == 0 && busy_o == 0, "R1 after release", {en_o, busy_o}, 0);

        // table of conversions on divided clocks
        for (int i = 0; i < 6; i++) begin
            vin = VEC[i][21:12];
            wr_ctl(1'b1, 1'b1, VEC[i][23:22]);
            chk(busy_o == 1, "R3 busy set", busy_o, 1);
            wait_idle(n);
            chk(n == int'(VEC[i][11:0]), "R3 conversion length", n, VEC[i][11:0]);
            chk(res == vin, "R3 result code", res, vin);
            chk(res_hi_o == vin[9:8] && res_lo_o == vin[7:0], "R4 result split", res, vin);
            chk(flag_o == 1, "R4 flag set with ie=0", flag_o, 1);
            pulse_clr();
            chk(flag_o == 0, "R4 flag cleared", flag_o, 0);
        end

        // R6 trigger while enabled
        vin = 10'h123;
        wr_ctl(1'b1, 1'b0, 2'd0);
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        chk(busy_o == 1, "R6 trigger starts", busy_o, 1);
        wait_idle(n);
        chk(n == 20, "R6 trigger conversion length", n, 20);
        chk(res == 10'h123, "R6 trigger result", res, 10'h123);
        pulse_clr();

        // R6 trigger while disabled
        wr_ctl(1'b0, 1'b0, 2'd0);
        vin = 10'h0F0;
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        chk(busy_o == 0, "R6 trigger ignored", busy_o, 0);
        repeat (30) @(negedge clk);
        chk(flag_o == 0 && res == 10'h123, "R6 no effect when off", res, 10'h123);

        // R11 go with enable=0
        wr_ctl(1'b0, 1'b1, 2'd0);
        chk(busy_o == 0, "R11 go without enable", busy_o, 0);
        repeat (30) @(negedge clk);
        chk(flag_o == 0 && res == 10'h123, "R11 nothing loaded", res, 10'h123);

        // R5 software abort
        wr_ctl(1'b1, 1'b1, 2'd1);
        repeat (20) @(negedge clk);
        wr_ctl(1'b1, 1'b0, 2'd1);
        chk(busy_o == 0, "R5 abort clears busy", busy_o, 0);
        repeat (100) @(negedge clk);
        chk(res == 10'h123, "R5 result kept", res, 10'h123);
        chk(flag_o == 0, "R5 no flag", flag_o, 0);

        // R7 RC clock with start delay
        rc_tick = 1'b1;
        vin = 10'h2C5;
        wr_ctl(1'b1, 1'b1, 2'b11);
        wait_idle(n);
        chk(n == 14, "R7 RC start delay", n, 14);
        chk(res == 10'h2C5, "R7 RC result", res, 10'h2C5);
        pulse_clr();

        // R8 RC in sleep, interrupt enabled
        ie = 1'b1; vin = 10'h0A7; w0 = wake_cnt;
        wr_ctl(1'b1, 1'b1, 2'b11);
        sleep = 1'b1;
        wait_idle(n);
        @(negedge clk);
        chk(wake_cnt - w0 == 1, "R8 one wake pulse", wake_cnt - w0, 1);
        chk(res == 10'h0A7, "R8 sleep result", res, 10'h0A7);
        chk(pwr_o == 1 && flag_o == 1, "R8 stays powered", {pwr_o, flag_o}, 3);
        sleep = 1'b0;
        pulse_clr();

        // R9 RC in sleep, interrupt disabled
        ie = 1'b0; vin = 10'h3C0; w0 = wake_cnt;
        wr_ctl(1'b1, 1'b1, 2'b11);
        sleep = 1'b1;
        wait_idle(n);
        chk(res == 10'h3C0 && flag_o == 1, "R9 result and flag", res, 10'h3C0);
        chk(pwr_o == 0, "R9 powered down", pwr_o, 0);
        chk(en_o == 1, "R9 enable kept", en_o, 1);
        chk(wake_cnt == w0, "R9 no wake", wake_cnt - w0, 0);
        sleep = 1'b0;
        @(negedge clk);
        chk(pwr_o == 1, "R9 power back after sleep", pwr_o, 1);
        pulse_clr();

        // R10 divided clock aborted by sleep
        vin = 10'h111;
        wr_ctl(1'b1, 1'b1, 2'd0);
        repeat (5) @(negedge clk);
        sleep = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && pwr_o == 0, "R10 sleep abort", {busy_o, pwr_o}, 0);
        chk(en_o == 1, "R10 enable kept", en_o, 1);
        repeat (50) @(negedge clk);
        chk(res == 10'h3C0 && flag_o == 0, "R10 result kept", res, 10'h3C0);
        sleep = 1'b0;
        @(negedge clk);
        chk(pwr_o == 1, "R10 power back", pwr_o, 1);

        // R1 / R2 reset in the middle of a conversion
        @(negedge clk); ana_we = 1'b1; ana_wdata = 7'h00;
        @(negedge clk); ana_we = 1'b0;
        chk(ana_sel_o == 7'h00, "R1 analog select written", ana_sel_o, 0);
        vin = 10'h055;
        wr_ctl(1'b1, 1'b1, 2'd1);
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(en_o == 0 && busy_o == 0 && pwr_o == 0, "R1 reset aborts", {en_o, busy_o, pwr_o}, 0);
        chk(ana_sel_o == 7'h7F, "R1 reset sets analog", ana_sel_o, 7'h7F);
        chk(res == 10'h3C0, "R2 result kept by reset", res, 10'h3C0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(res == 10'h3C0 && busy_o == 0, "R2 result after release", res, 10'h3C0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule